// File: doc/BRIEF.md
# Tag-Indexed Range Translation Front End

This block sits after address generation and decides how a 64-bit pointer is translated. The upper 16 bits of the pointer act as a tag. A tag of all zeros or all ones marks an ordinary address, which is forwarded to the page TLB. Any other tag is a range identifier. The identifier selects one entry of a small fully associative range buffer directly, so no address comparison is needed to find the entry.

The selected entry holds a lower bound, an upper bound and a signed offset, stored as a modulo-2^48 addend. If the 48-bit address lies inside the bounds, the physical address is the address plus the offset. If it lies outside, the access goes to the page TLB. An unknown identifier, or an out-of-bounds access through a placeholder ("dummy") entry, raises a miss so that an external walker can fetch the translation.

The walker writes results back through a single fill port. A fill for an identifier that is already held overwrites that entry. Each request produces exactly one registered outcome one cycle later.

Top module: `rxl_front`

## Requirements
- R1: A request whose tag (ptr[63:48]) is 16'h0000 or 16'hFFFF yields the redirect outcome, whatever the table holds. fwd_ptr_o always carries the pointer of the last request.
- R2: A request with any other tag yields the miss outcome when no valid entry holds that tag as its identifier.
- R3: A request that matches a non-dummy entry with base <= ptr[47:0] < limit yields the hit outcome, with pa_o = (ptr[47:0] + delta) mod 2^48.
- R4: A request that matches a non-dummy entry with ptr[47:0] < base or ptr[47:0] >= limit yields the redirect outcome.
- R5: A request that matches a dummy entry yields redirect when the address is inside the bounds, and miss when it is outside.
- R6: Each request held in req_valid_i at a rising edge sets exactly one of hit_o, redir_o and miss_o for the cycle after that edge. A cycle without a request sets none of them.
- R7: A fill whose identifier is already held overwrites that entry's dummy flag, bounds and offset in place and takes no further slot.
- R8: A fill with a new identifier goes to the lowest-numbered free slot. When no slot is free, it evicts slots in round-robin order starting at slot 0, advancing once per eviction.
- R9: A lookup in the same cycle as a fill sees the table as it was before that fill.
- R10: After reset every entry is invalid and all outputs are zero.
- R11: pa_o is zero in every cycle where hit_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request strobe |
| req_ptr_i | input | 64 | Tagged pointer to translate |
| fill_valid_i | input | 1 | Walker fill strobe |
| fill_id_i | input | 16 | Range identifier being filled |
| fill_dummy_i | input | 1 | Fill is a placeholder entry |
| fill_base_i | input | 48 | Inclusive lower bound |
| fill_limit_i | input | 48 | Exclusive upper bound |
| fill_delta_i | input | 48 | Offset added to the address |
| hit_o | output | 1 | Range translation succeeded |
| redir_o | output | 1 | Send request to page TLB |
| miss_o | output | 1 | Request range walk |
| pa_o | output | 48 | Physical address on hit |
| fwd_ptr_o | output | 64 | Pointer of the last request |

## Verification
The bench probes both ends of the bounds. An address equal to the lower bound must hit and an address equal to the upper bound must redirect, so a design that swaps the inclusive and exclusive ends fails there. Tags one step away from the ordinary encodings (0x0001 and 0xFFFE) must be treated as range identifiers, which catches a classifier that only looks at one or a few bits. The bench also checks a sum that wraps past 2^48, the two dummy outcomes, and a same-cycle fill and lookup. A same-identifier refill followed by enough new fills to force evictions exposes a design that keeps duplicates or picks the wrong victim: the wrong identifier is lost.

// File: rtl/rxl_pkg.sv
package rxl_pkg;
  typedef enum logic [1:0] {
    OUT_NONE = 2'd0,
    OUT_HIT  = 2'd1,
    OUT_PAGE = 2'd2,
    OUT_MISS = 2'd3
  } rxl_out_e;
endpackage

// File: rtl/rxl_classify.sv
module rxl_classify #(
  parameter int PTR_W  = 64,
  parameter int ADDR_W = 48,
  localparam int ID_W  = PTR_W - ADDR_W
) (
  input  logic [PTR_W-1:0]  ptr_i,
  output logic              is_range_o,
  output logic [ID_W-1:0]   id_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ID_W-1:0] tag;
  logic            all_zero;
  logic            all_one;

  always_comb begin
    tag        = ptr_i[PTR_W-1:ADDR_W];
    all_zero   = (tag == '0);
    all_one    = (tag == '1);
    is_range_o = !(all_zero || all_one);
    id_o       = tag;
    addr_o     = ptr_i[ADDR_W-1:0];
  end
endmodule

// File: rtl/rxl_store.sv
module rxl_store #(
  parameter int N      = 16,
  parameter int ID_W   = 16,
  parameter int ADDR_W = 48,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        fill_valid_i,
  input  logic [ID_W-1:0]             fill_id_i,
  input  logic                        fill_dummy_i,
  input  logic [ADDR_W-1:0]           fill_base_i,
  input  logic [ADDR_W-1:0]           fill_limit_i,
  input  logic [ADDR_W-1:0]           fill_delta_i,
  output logic [N-1:0]                vld_o,
  output logic [N-1:0]                dmy_o,
  output logic [N-1:0][ID_W-1:0]      id_o,
  output logic [N-1:0][ADDR_W-1:0]    base_o,
  output logic [N-1:0][ADDR_W-1:0]    limit_o,
  output logic [N-1:0][ADDR_W-1:0]    delta_o
);
  logic [N-1:0]     same_id;
  logic             same_any;
  logic             free_any;
  logic [IDX_W-1:0] same_idx;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] victim_q;
  logic             evict;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign same_id[g] = vld_o[g] && (id_o[g] == fill_id_i);
  end

  // priority pick: existing id, else lowest free slot, else victim
  always_comb begin
    same_any = 1'b0;
    same_idx = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (same_id[i]) begin
        same_any = 1'b1;
        same_idx = IDX_W'(i);
      end
      if (!vld_o[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    evict = !same_any && !free_any;
    if (same_any)      wr_idx = same_idx;
    else if (free_any) wr_idx = free_idx;
    else               wr_idx = victim_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      victim_q <= '0;
    end else if (fill_valid_i && evict) begin
      if (victim_q == IDX_W'(N - 1)) victim_q <= '0;
      else                           victim_q <= victim_q + 1'b1;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic wr_en;
    assign wr_en = fill_valid_i && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[g]   <= 1'b0;
        dmy_o[g]   <= 1'b0;
        id_o[g]    <= '0;
        base_o[g]  <= '0;
        limit_o[g] <= '0;
        delta_o[g] <= '0;
      end else if (wr_en) begin
        vld_o[g]   <= 1'b1;
        dmy_o[g]   <= fill_dummy_i;
        id_o[g]    <= fill_id_i;
        base_o[g]  <= fill_base_i;
        limit_o[g] <= fill_limit_i;
        delta_o[g] <= fill_delta_i;
      end
    end
  end
endmodule

// File: rtl/rxl_match.sv
module rxl_match #(
  parameter int N      = 16,
  parameter int ID_W   = 16,
  parameter int ADDR_W = 48
) (
  input  logic [ID_W-1:0]             id_i,
  input  logic [N-1:0]                vld_i,
  input  logic [N-1:0]                dmy_i,
  input  logic [N-1:0][ID_W-1:0]      ids_i,
  input  logic [N-1:0][ADDR_W-1:0]    base_i,
  input  logic [N-1:0][ADDR_W-1:0]    limit_i,
  input  logic [N-1:0][ADDR_W-1:0]    delta_i,
  output logic                        found_o,
  output logic                        dmy_o,
  output logic [ADDR_W-1:0]           base_o,
  output logic [ADDR_W-1:0]           limit_o,
  output logic [ADDR_W-1:0]           delta_o
);
  logic [N-1:0] sel;

  for (genvar g = 0; g < N; g++) begin : g_sel
    assign sel[g] = vld_i[g] && (ids_i[g] == id_i);
  end

  // ids are unique, so an OR-mux over the one-hot select is exact
  always_comb begin
    found_o = |sel;
    dmy_o   = 1'b0;
    base_o  = '0;
    limit_o = '0;
    delta_o = '0;
    for (int i = 0; i < N; i++) begin
      dmy_o   = dmy_o   | (sel[i] & dmy_i[i]);
      base_o  = base_o  | ({ADDR_W{sel[i]}} & base_i[i]);
      limit_o = limit_o | ({ADDR_W{sel[i]}} & limit_i[i]);
      delta_o = delta_o | ({ADDR_W{sel[i]}} & delta_i[i]);
    end
  end
endmodule

// File: rtl/rxl_resolve.sv
module rxl_resolve
  import rxl_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic              is_range_i,
  input  logic              found_i,
  input  logic              dmy_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] limit_i,
  input  logic [ADDR_W-1:0] delta_i,
  output rxl_out_e          out_o,
  output logic [ADDR_W-1:0] pa_o
);
  logic in_bnd;

  always_comb begin
    in_bnd = (addr_i >= base_i) && (addr_i < limit_i);
    pa_o   = addr_i + delta_i;
    if (!is_range_i)  out_o = OUT_PAGE;
    else if (!found_i) out_o = OUT_MISS;
    else if (dmy_i)   out_o = in_bnd ? OUT_PAGE : OUT_MISS;
    else              out_o = in_bnd ? OUT_HIT  : OUT_PAGE;
  end
endmodule

// File: rtl/rxl_front.sv
module rxl_front
  import rxl_pkg::*;
#(
  parameter int PTR_W   = 64,
  parameter int ADDR_W  = 48,
  parameter int ENTRIES = 16,
  localparam int ID_W   = PTR_W - ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [PTR_W-1:0]  req_ptr_i,
  input  logic              fill_valid_i,
  input  logic [ID_W-1:0]   fill_id_i,
  input  logic              fill_dummy_i,
  input  logic [ADDR_W-1:0] fill_base_i,
  input  logic [ADDR_W-1:0] fill_limit_i,
  input  logic [ADDR_W-1:0] fill_delta_i,
  output logic              hit_o,
  output logic              redir_o,
  output logic              miss_o,
  output logic [ADDR_W-1:0] pa_o,
  output logic [PTR_W-1:0]  fwd_ptr_o
);
  logic                          is_range;
  logic [ID_W-1:0]               req_id;
  logic [ADDR_W-1:0]             req_addr;
  logic [ENTRIES-1:0]            e_vld;
  logic [ENTRIES-1:0]            e_dmy;
  logic [ENTRIES-1:0][ID_W-1:0]  e_id;
  logic [ENTRIES-1:0][ADDR_W-1:0] e_base;
  logic [ENTRIES-1:0][ADDR_W-1:0] e_limit;
  logic [ENTRIES-1:0][ADDR_W-1:0] e_delta;
  logic                          m_found;
  logic                          m_dmy;
  logic [ADDR_W-1:0]             m_base;
  logic [ADDR_W-1:0]             m_limit;
  logic [ADDR_W-1:0]             m_delta;
  rxl_out_e                      res_out;
  logic [ADDR_W-1:0]             res_pa;

  rxl_classify #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_cls (
    .ptr_i      (req_ptr_i),
    .is_range_o (is_range),
    .id_o       (req_id),
    .addr_o     (req_addr)
  );

  rxl_store #(.N(ENTRIES), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fill_valid_i (fill_valid_i),
    .fill_id_i    (fill_id_i),
    .fill_dummy_i (fill_dummy_i),
    .fill_base_i  (fill_base_i),
    .fill_limit_i (fill_limit_i),
    .fill_delta_i (fill_delta_i),
    .vld_o        (e_vld),
    .dmy_o        (e_dmy),
    .id_o         (e_id),
    .base_o       (e_base),
    .limit_o      (e_limit),
    .delta_o      (e_delta)
  );

  rxl_match #(.N(ENTRIES), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_match (
    .id_i    (req_id),
    .vld_i   (e_vld),
    .dmy_i   (e_dmy),
    .ids_i   (e_id),
    .base_i  (e_base),
    .limit_i (e_limit),
    .delta_i (e_delta),
    .found_o (m_found),
    .dmy_o   (m_dmy),
    .base_o  (m_base),
    .limit_o (m_limit),
    .delta_o (m_delta)
  );

  rxl_resolve #(.ADDR_W(ADDR_W)) u_res (
    .is_range_i (is_range),
    .found_i    (m_found),
    .dmy_i      (m_dmy),
    .addr_i     (req_addr),
    .base_i     (m_base),
    .limit_i    (m_limit),
    .delta_i    (m_delta),
    .out_o      (res_out),
    .pa_o       (res_pa)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o     <= 1'b0;
      redir_o   <= 1'b0;
      miss_o    <= 1'b0;
      pa_o      <= '0;
      fwd_ptr_o <= '0;
    end else begin
      hit_o   <= req_valid_i && (res_out == OUT_HIT);
      redir_o <= req_valid_i && (res_out == OUT_PAGE);
      miss_o  <= req_valid_i && (res_out == OUT_MISS);
      pa_o    <= (req_valid_i && (res_out == OUT_HIT)) ? res_pa : '0;
      if (req_valid_i) fwd_ptr_o <= req_ptr_i;
    end
  end
endmodule

// File: rtl/rxl_front_chk.sv
module rxl_front_chk #(
  parameter int PTR_W  = 64,
  parameter int ADDR_W = 48
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [PTR_W-1:0]  req_ptr_i,
  input logic              hit_o,
  input logic              redir_o,
  input logic              miss_o,
  input logic [ADDR_W-1:0] pa_o,
  input logic [PTR_W-1:0]  fwd_ptr_o
);
  logic req_normal;
  logic fwd_normal;
  assign req_normal = (req_ptr_i[PTR_W-1:ADDR_W] == '0) || (req_ptr_i[PTR_W-1:ADDR_W] == '1);
  assign fwd_normal = (fwd_ptr_o[PTR_W-1:ADDR_W] == '0) || (fwd_ptr_o[PTR_W-1:ADDR_W] == '1);

  p_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hit_o, redir_o, miss_o}));

  p_one_per_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> ($countones({hit_o, redir_o, miss_o}) == 1));

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ({hit_o, redir_o, miss_o} == 3'b000));

  p_normal_redir_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_normal) |=> redir_o);

  p_fwd_ptr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (fwd_ptr_o == $past(req_ptr_i)));

  p_hit_tagged_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> !fwd_normal);

  p_pa_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (pa_o == '0));
endmodule

bind rxl_front rxl_front_chk #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ptr_i   (req_ptr_i),
  .hit_o       (hit_o),
  .redir_o     (redir_o),
  .miss_o      (miss_o),
  .pa_o        (pa_o),
  .fwd_ptr_o   (fwd_ptr_o)
);

// File: tb/sim_rxl_front.sv
`timescale 1ns/1ps
module sim_rxl_front;
  localparam logic [2:0] E_HIT = 3'b001;
  localparam logic [2:0] E_RED = 3'b010;
  localparam logic [2:0] E_MIS = 3'b100;
  localparam int NV = 13;

  typedef struct packed {
    logic [63:0] ptr;
    logic [2:0]  exp;
    logic [47:0] pa;
  } vec_t;

  // table populated by the fills done before the walk (see setup)
  localparam vec_t VT [NV] = '{
    '{64'h0000_0000_0000_1234, E_RED, 48'h0},             // R1 zero tag
    '{64'hFFFF_8000_0000_1234, E_RED, 48'h0},             // R1 ones tag
    '{64'h0011_0000_0000_1000, E_HIT, 48'h0000_0010_1000}, // R3 base inclusive
    '{64'h0011_0000_0000_1FFF, E_HIT, 48'h0000_0010_1FFF}, // R3 last in range
    '{64'h0011_0000_0000_2000, E_RED, 48'h0},             // R4 limit exclusive
    '{64'h0011_0000_0000_0FFF, E_RED, 48'h0},             // R4 below base
    '{64'h0022_0000_8000_0010, E_HIT, 48'hFFFF_8000_0010}, // R3 large delta
    '{64'h0033_FFFF_FFFF_0010, E_HIT, 48'h0000_0000_0010}, // R3 wrap mod 2^48
    '{64'h0044_0000_0000_4800, E_RED, 48'h0},             // R5 dummy inside
    '{64'h0044_0000_0000_5000, E_MIS, 48'h0},             // R5 dummy outside
    '{64'h0055_0000_0000_1000, E_MIS, 48'h0},             // R2 unknown id
    '{64'h0001_0000_0000_1000, E_MIS, 48'h0},             // R2 tag near zero
    '{64'hFFFE_0000_0000_1000, E_MIS, 48'h0}              // R2 tag near ones
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [63:0] req_ptr_i = '0;
  logic        fill_valid_i = 1'b0;
  logic [15:0] fill_id_i = '0;
  logic        fill_dummy_i = 1'b0;
  logic [47:0] fill_base_i = '0;
  logic [47:0] fill_limit_i = '0;
  logic [47:0] fill_delta_i = '0;
  logic        hit_o, redir_o, miss_o;
  logic [47:0] pa_o;
  logic [63:0] fwd_ptr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  rxl_front u0 (.*);

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic fill(logic [15:0] id, logic dmy, logic [47:0] b, logic [47:0] l, logic [47:0] d);
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_id_i = id; fill_dummy_i = dmy;
    fill_base_i = b; fill_limit_i = l; fill_delta_i = d;
    @(negedge clk_i);
    fill_valid_i = 1'b0;
  endtask

  // drive at a negedge, result registered at next posedge, sampled at following negedge
  task automatic look(logic [63:0] p, string tag, logic [2:0] exp, logic [47:0] epa);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_ptr_i = p;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(tag, {61'd0, miss_o, redir_o, hit_o}, {61'd0, exp});
    chk(tag, {16'd0, pa_o}, {16'd0, epa});
    chk(tag, fwd_ptr_o, p);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R10 reset outcome", {61'd0, miss_o, redir_o, hit_o}, 64'd0);
    chk("R10 reset pa", {16'd0, pa_o}, 64'd0);
    chk("R10 reset fwd", fwd_ptr_o, 64'd0);
    rst_ni = 1'b1;
    look(64'h0011_0000_0000_1000, "R10 empty table miss", E_MIS, 48'h0);

    fill(16'h0011, 1'b0, 48'h1000, 48'h2000, 48'h10_0000);
    fill(16'h0022, 1'b0, 48'h8000_0000, 48'h8000_1000, 48'hFFFF_0000_0000);
    fill(16'h0033, 1'b0, 48'hFFFF_FFFF_0000, 48'hFFFF_FFFF_FFFF, 48'h1_0000);
    fill(16'h0044, 1'b1, 48'h4000, 48'h5000, 48'h0);

    for (int i = 0; i < NV; i++)
      look(VT[i].ptr, $sformatf("R%0d vec %0d", (VT[i].exp == E_HIT) ? 3 : 6, i), VT[i].exp, VT[i].pa);

    // R6 idle cycle produces no outcome
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R6 idle no outcome", {61'd0, miss_o, redir_o, hit_o}, 64'd0);

    // R9 same-cycle fill and lookup of a new id
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_id_i = 16'h0066; fill_dummy_i = 1'b0;
    fill_base_i = 48'h0; fill_limit_i = 48'h100; fill_delta_i = 48'h7;
    req_valid_i = 1'b1; req_ptr_i = 64'h0066_0000_0000_0010;
    @(negedge clk_i);
    fill_valid_i = 1'b0; req_valid_i = 1'b0;
    chk("R9 old contents seen", {61'd0, miss_o, redir_o, hit_o}, {61'd0, E_MIS});
    look(64'h0066_0000_0000_0010, "R9 visible next cycle", E_HIT, 48'h17);

    // R7 refill existing id in place
    fill(16'h0011, 1'b0, 48'h3000, 48'h4000, 48'h20);
    look(64'h0011_0000_0000_1000, "R7 old bounds gone", E_RED, 48'h0);
    look(64'h0011_0000_0000_3000, "R7 new bounds used", E_HIT, 48'h3020);

    // fill remaining 11 slots; table full with no eviction yet
    for (int k = 0; k < 11; k++)
      fill(16'h0100 + 16'(k), 1'b0, 48'h0, 48'h100, 48'h1);
    look(64'h0022_0000_8000_0010, "R7 no slot wasted", E_HIT, 48'hFFFF_8000_0010);
    look(64'h010A_0000_0000_0020, "R8 last slot filled", E_HIT, 48'h21);

    // R8 eviction order from slot 0
    fill(16'h0200, 1'b0, 48'h0, 48'h100, 48'h5);
    look(64'h0200_0000_0000_0010, "R8 new id resident", E_HIT, 48'h15);
    look(64'h0011_0000_0000_3000, "R8 slot0 evicted", E_MIS, 48'h0);
    look(64'h0022_0000_8000_0010, "R8 slot1 kept", E_HIT, 48'hFFFF_8000_0010);
    fill(16'h0201, 1'b0, 48'h0, 48'h100, 48'h5);
    look(64'h0022_0000_8000_0010, "R8 slot1 evicted next", E_MIS, 48'h0);
    look(64'h0033_FFFF_FFFF_0010, "R8 slot2 kept", E_HIT, 48'h10);
    look(64'h0000_0000_0000_0022, "R1 normal after fills", E_RED, 48'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got running exp done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule